// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block holds the programmable setup of eight memory protection regions behind a small word-wide register port. Software picks one region through a selector register and then reads or writes that region's base-address word and attribute/size word. Three more pairs of addresses lead to the same selected-region pair, so software can program several regions with a burst of stores. A base-address store can reload the selector in the same access, which lets software choose a region and place it in one write.

The stored base addresses and attribute words of all regions, along with three global control bits, leave the block as flat vectors toward a separate access checker. That checker matches addresses and reports faults. This bank only stores, masks and returns configuration. It has a fixed read-only identification word that gives the region count.

Top module: `region_cfg_bank`

## Requirements
- R1: After reset the control bits, the selector, and every region's base and attribute words are zero.
- R2: Byte offset 0xD90 is read-only and reads 0x0000_0800: the data-region count (8) in bits [15:8], with the instruction-region count and the unified-map flag (bit 0) both zero. Writes to it change nothing.
- R3: Offset 0xD94 holds three writable bits: bit 0 is the global enable (`ctl_enable`), bit 1 keeps protection active inside fault and non-maskable handlers (`ctl_fault_en`), and bit 2 turns on the background map for privileged accesses (`ctl_bg_en`). Bits [31:3] read zero. The ports follow a write on the next cycle.
- R4: Offset 0xD98 is the region selector. A write keeps only bits [2:0], and a read returns the selector in bits [2:0] with the other bits zero.
- R5: A write to a base-address offset with bit 4 clear stores bits [31:5] as the base of the currently selected region. The selector stays the same and bits [3:0] are ignored.
- R6: A write to a base-address offset with bit 4 set loads the selector from bits [2:0]. In the same cycle it stores bits [31:5] as that newly selected region's base.
- R7: A base-address read returns the selected region's base in [31:5], zero in bit 4 and the selector in [3:0].
- R8: Offset 0xDA0 accesses the selected region's attribute word. The writable bits are 28, [26:24], [21:16], [15:8] and [5:0] (mask 0x173F_FF3F). Every other bit is stored and read as zero.
- R9: Offsets 0xDA4/0xDA8, 0xDAC/0xDB0 and 0xDB4/0xDB8 act exactly like the base/attribute pair at 0xD9C/0xDA0.
- R10: A write to any other byte offset, including an unaligned one, changes nothing. A read of such an offset returns zero.
- R11: Read data appears on `bus_rdata` one clock after the read request. Region `i` is exported on `region_base[27*i +: 27]` and `region_attr[32*i +: 32]`, and each changes on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctl_enable | output | 1 | Global protection enable |
| ctl_fault_en | output | 1 | Protection active in fault handlers |
| ctl_bg_en | output | 1 | Background map for privileged accesses |
| region_base | output | 216 | Base bits [31:5] of all regions, region 0 lowest |
| region_attr | output | 256 | Masked attribute words of all regions, region 0 lowest |

## Verification
A write is taken on one rising edge, and both the exported vectors and any later read reflect it from that edge on. Read data is registered, so it is due exactly one edge after the request. The bench drives every request on a falling edge and samples the read word on the next falling edge, half a cycle after the edge that loads it. The reference model is updated when the write is issued, so a read that follows a write is compared against post-write state. The exported ports are compared on falling edges after write sequences, never at a rising edge.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;
  localparam int NUM_REGIONS_DEF = 8;
  localparam int DATA_W          = 32;
  localparam int OFS_W           = 12;
  localparam int BASE_LSB        = 5;
  localparam int NUM_PAIRS       = 4;

  localparam logic [OFS_W-1:0] OFS_IDENT = 12'hD90;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 12'hD94;
  localparam logic [OFS_W-1:0] OFS_SEL   = 12'hD98;
  localparam logic [OFS_W-1:0] OFS_BASE0 = 12'hD9C;
  localparam logic [OFS_W-1:0] OFS_ATTR0 = 12'hDA0;
  localparam int               PAIR_STEP = 8;

  typedef enum logic [2:0] {
    K_NONE, K_IDENT, K_CTRL, K_SEL, K_BASE, K_ATTR
  } reg_kind_e;

  // Writable attribute bits: XN, AP, TEX/S/C/B, subregion disables, SIZE, ENABLE
  function automatic logic [DATA_W-1:0] attr_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[28]    = 1'b1;
    m[26:24] = '1;
    m[21:16] = '1;
    m[15:8]  = '1;
    m[5:0]   = '1;
    return m;
  endfunction

  function automatic reg_kind_e decode_offset(input logic [OFS_W-1:0] a);
    reg_kind_e k;
    k = K_NONE;
    if (a == OFS_IDENT) k = K_IDENT;
    if (a == OFS_CTRL)  k = K_CTRL;
    if (a == OFS_SEL)   k = K_SEL;
    for (int n = 0; n < NUM_PAIRS; n++) begin
      if (a == OFS_BASE0 + OFS_W'(PAIR_STEP * n)) k = K_BASE;
      if (a == OFS_ATTR0 + OFS_W'(PAIR_STEP * n)) k = K_ATTR;
    end
    return k;
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import prot_cfg_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  output reg_kind_e        kind
);
  always_comb kind = decode_offset(addr);
endmodule

// File: rtl/region_slot.sv
module region_slot
  import prot_cfg_pkg::*;
#(
  parameter int BASE_W = DATA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              attr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q,
  output logic [DATA_W-1:0] attr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      attr_q <= '0;
    end else begin
      if (base_we) base_q <= wdata[DATA_W-1:BASE_LSB];
      if (attr_we) attr_q <= wdata & attr_mask();
    end
  end
endmodule

// File: rtl/region_cfg_bank.sv
module region_cfg_bank
  import prot_cfg_pkg::*;
#(
  parameter int NUM_REGIONS = NUM_REGIONS_DEF,
  parameter int SEL_W       = $clog2(NUM_REGIONS),
  parameter int BASE_W      = DATA_W - BASE_LSB
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic [OFS_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          ctl_enable,
  output logic                          ctl_fault_en,
  output logic                          ctl_bg_en,
  output logic [NUM_REGIONS*BASE_W-1:0] region_base,
  output logic [NUM_REGIONS*DATA_W-1:0] region_attr
);
  localparam int PAD_W = BASE_LSB - SEL_W;
  localparam logic [DATA_W-1:0] IDENT_WORD = {16'h0, 8'(NUM_REGIONS), 8'h0};

  reg_kind_e         kind;
  logic [SEL_W-1:0]  sel_q;
  logic [2:0]        ctrl_q;
  logic [BASE_W-1:0] base_arr [NUM_REGIONS];
  logic [DATA_W-1:0] attr_arr [NUM_REGIONS];
  logic [DATA_W-1:0] rd_word;

  // named events, visible to the checker
  logic wr_acc, rd_acc, wr_ctrl, wr_sel, wr_base, wr_attr, base_reload;
  logic [SEL_W-1:0] base_target;

  cfg_addr_decode u_dec (.addr(bus_addr), .kind(kind));

  assign wr_acc      = bus_valid &  bus_write;
  assign rd_acc      = bus_valid & ~bus_write;
  assign wr_ctrl     = wr_acc && (kind == K_CTRL);
  assign wr_sel      = wr_acc && (kind == K_SEL);
  assign wr_base     = wr_acc && (kind == K_BASE);
  assign wr_attr     = wr_acc && (kind == K_ATTR);
  assign base_reload = wr_base && bus_wdata[4];
  assign base_target = base_reload ? bus_wdata[SEL_W-1:0] : sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_sel)           sel_q  <= bus_wdata[SEL_W-1:0];
      else if (base_reload) sel_q  <= bus_wdata[SEL_W-1:0];
      if (wr_ctrl)          ctrl_q <= bus_wdata[2:0];
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    region_slot #(.BASE_W(BASE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (wr_base && (base_target == SEL_W'(i))),
      .attr_we (wr_attr && (sel_q == SEL_W'(i))),
      .wdata   (bus_wdata),
      .base_q  (base_arr[i]),
      .attr_q  (attr_arr[i])
    );
    assign region_base[i*BASE_W +: BASE_W] = base_arr[i];
    assign region_attr[i*DATA_W +: DATA_W] = attr_arr[i];
  end

  always_comb begin
    unique case (kind)
      K_IDENT: rd_word = IDENT_WORD;
      K_CTRL:  rd_word = {{(DATA_W-3){1'b0}}, ctrl_q};
      K_SEL:   rd_word = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      K_BASE:  rd_word = {base_arr[sel_q], {PAD_W{1'b0}}, sel_q};
      K_ATTR:  rd_word = attr_arr[sel_q];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_word;
  end

  assign ctl_enable   = ctrl_q[0];
  assign ctl_fault_en = ctrl_q[1];
  assign ctl_bg_en    = ctrl_q[2];
endmodule

// File: rtl/region_cfg_bank_chk.sv
module region_cfg_bank_chk #(
  parameter int SEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ctl_enable,
  input logic              ctl_fault_en,
  input logic              ctl_bg_en,
  input logic [SEL_W-1:0]  sel_q,
  input logic              wr_base,
  input logic              wr_sel
);
  logic is_base_ofs, is_ident_ofs, is_ctrl_ofs, is_known;
  assign is_base_ofs  = (bus_addr == 12'hD9C) || (bus_addr == 12'hDA4) ||
                        (bus_addr == 12'hDAC) || (bus_addr == 12'hDB4);
  assign is_ident_ofs = (bus_addr == 12'hD90);
  assign is_ctrl_ofs  = (bus_addr == 12'hD94);
  assign is_known     = (bus_addr >= 12'hD90) && (bus_addr <= 12'hDB8) &&
                        (bus_addr[1:0] == 2'b00);

  a_r2_ident_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && is_ident_ofs) |=> (bus_rdata == 32'h0000_0800));

  a_r3_ctrl_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_ctrl_ofs) |=>
      ({ctl_bg_en, ctl_fault_en, ctl_enable} == $past(bus_wdata[2:0])));

  a_r3_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && is_ctrl_ofs) |=>
      $stable({ctl_bg_en, ctl_fault_en, ctl_enable}));

  a_r5_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && !bus_wdata[4] && !wr_sel) |=> $stable(sel_q));

  a_r6_sel_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_base_ofs && bus_wdata[4]) |=>
      (sel_q == $past(bus_wdata[SEL_W-1:0])));

  a_r7_base_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && is_base_ofs) |=>
      (bus_rdata[4:0] == 5'($past(sel_q))));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !is_known) |=> (bus_rdata == 32'h0));
endmodule

bind region_cfg_bank region_cfg_bank_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ctl_enable(ctl_enable), .ctl_fault_en(ctl_fault_en), .ctl_bg_en(ctl_bg_en),
  .sel_q(sel_q), .wr_base(wr_base), .wr_sel(wr_sel)
);

// File: tb/test_region_cfg_bank.sv
`timescale 1ns/1ps
module test_region_cfg_bank;
  localparam int NR = 8;
  localparam int BW = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ctl_enable, ctl_fault_en, ctl_bg_en;
  logic [NR*BW-1:0] region_base;
  logic [NR*32-1:0] region_attr;

  region_cfg_bank i_region_cfg_bank (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [26:0] m_base [NR];
  logic [31:0] m_attr [NR];
  logic [2:0]  m_sel, m_ctrl;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] keep_bits();
    int hi [5] = '{28, 26, 21, 15, 5};
    int lo [5] = '{28, 24, 16, 8, 0};
    logic [31:0] m = 0;
    for (int f = 0; f < 5; f++)
      for (int b = lo[f]; b <= hi[f]; b++) m |= 32'(1) << b;
    return m;
  endfunction

  function automatic bit is_base(logic [11:0] a);
    return a == 12'hD9C || a == 12'hDA4 || a == 12'hDAC || a == 12'hDB4;
  endfunction
  function automatic bit is_attr(logic [11:0] a);
    return a == 12'hDA0 || a == 12'hDA8 || a == 12'hDB0 || a == 12'hDB8;
  endfunction

  function automatic logic [31:0] expect_rd(logic [11:0] a);
    if (a == 12'hD90) return 32'h800;
    if (a == 12'hD94) return {29'h0, m_ctrl};
    if (a == 12'hD98) return {29'h0, m_sel};
    if (is_base(a))   return {m_base[m_sel], 2'b00, m_sel};
    if (is_attr(a))   return m_attr[m_sel];
    return 32'h0;
  endfunction

  function automatic string req_of(logic [11:0] a);
    if (a == 12'hD90) return "R2";
    if (a == 12'hD94) return "R3";
    if (a == 12'hD98) return "R4";
    if (is_base(a))   return (a == 12'hD9C) ? "R7" : "R9";
    if (is_attr(a))   return (a == 12'hDA0) ? "R8" : "R9";
    return "R10";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    if (a == 12'hD94) m_ctrl = d[2:0];
    if (a == 12'hD98) m_sel = d[2:0];
    if (is_base(a)) begin
      if (d[4]) m_sel = d[2:0];
      m_base[m_sel] = d[31:5];
    end
    if (is_attr(a)) m_attr[m_sel] = d & keep_bits();
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_check(logic [11:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    e = expect_rd(a);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0;
    check(req, bus_rdata, e);
  endtask

  task automatic check_ports(string req);
    for (int r = 0; r < NR; r++) begin
      check(req, 32'(region_base[r*BW +: BW]), 32'(m_base[r]));
      check(req, region_attr[r*32 +: 32], m_attr[r]);
    end
    check(req, {29'h0, ctl_bg_en, ctl_fault_en, ctl_enable}, {29'h0, m_ctrl});
  endtask

  initial begin
    logic [11:0] ofs [15] = '{12'hD90, 12'hD94, 12'hD98, 12'hD9C, 12'hDA0,
                              12'hDA4, 12'hDA8, 12'hDAC, 12'hDB0, 12'hDB4,
                              12'hDB8, 12'hD8C, 12'hDBC, 12'h000, 12'hD9E};
    void'($urandom(32'h5EED));
    m_sel = 0; m_ctrl = 0;
    for (int r = 0; r < NR; r++) begin m_base[r] = 0; m_attr[r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    check_ports("R1");
    rd_check(12'hD98, "R1");
    // R2: identification word, write ignored
    wr(12'hD90, 32'hFFFF_FFFF);
    rd_check(12'hD90, "R2");
    // R3: control bits, upper bits dropped
    wr(12'hD94, 32'hFFFF_FFFD);
    rd_check(12'hD94, "R3");
    check_ports("R3");
    // R4: selector keeps only low bits
    wr(12'hD98, 32'h0000_00FD);
    rd_check(12'hD98, "R4");
    // R5: valid clear, region field ignored
    wr(12'hD9C, 32'hABCD_E0EA);
    rd_check(12'hD98, "R5");
    check_ports("R5");
    // R6: valid set reloads selector
    wr(12'hD9C, 32'h1234_5673);
    rd_check(12'hD98, "R6");
    check_ports("R6");
    // R7: base readback layout
    rd_check(12'hD9C, "R7");
    // R8: attribute masking
    wr(12'hDA0, 32'hFFFF_FFFF);
    rd_check(12'hDA0, "R8");
    // R9: alias pair reaches a new region and the same storage
    wr(12'hDB4, 32'h8000_0011);
    wr(12'hDB8, 32'h0500_2A0B);
    rd_check(12'hDA0, "R9");
    rd_check(12'hDAC, "R9");
    // R10: unmapped and unaligned offsets
    wr(12'hDBC, 32'hFFFF_FFFF);
    wr(12'hD9E, 32'hFFFF_FFFF);
    rd_check(12'hDBC, "R10");
    rd_check(12'hD9E, "R10");
    check_ports("R10");
    // R11: read data due one edge after request; exports follow writes
    rd_check(12'hD90, "R11");
    check_ports("R11");

    for (int it = 0; it < 400; it++) begin
      logic [11:0] a = ofs[$urandom_range(0, 14)];
      if ($urandom_range(0, 1) == 1) wr(a, $urandom());
      else rd_check(a, req_of(a));
      if (it % 50 == 49) check_ports("R11");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule